// File: doc/BRIEF.md
# Grouped Lookahead Binary Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out. It is purely combinational. It is intended as the datapath adder of a larger pipeline stage, where it sits between registers owned by the surrounding logic.

The operands are split into 4-bit slices. Inside a slice, four full adders form a short ripple chain that produces the slice's sum bits. Alongside that chain, each slice reduces its per-column generate and propagate terms to a single slice generate and a single slice propagate. A separate carry unit uses these pairs to form the carry into every slice. Each step of that chain is one AND-OR term, so a carry never has to ripple through the four columns of a slice to reach the next one.

Top module: `cla_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals the (WIDTH+1)-bit unsigned value `a_i + b_i + cin_i` for every input combination.
- R2: In each column, generate is `a & b` and propagate is `a | b`. A column's carry-out is `gen | (prop & carry_in)`.
- R3: For a slice, generate is `g3 | p3&g2 | p3&p2&g1 | p3&p2&p1&g0` and propagate is `p0&p1&p2&p3`, where column 0 is the least significant column of the slice.
- R4: The carry into slice 0 is `cin_i`. The carry into slice k+1 is `G_k | (P_k & c_k)`, formed from slice k's generate and propagate and from slice k's own carry-in.
- R5: Within a slice, the sum bits come from a four-stage full-adder ripple. The ripple carry-out of each slice equals the lookahead carry into the next slice.
- R6: `cout_o` equals the lookahead carry-out of the most significant slice.
- R7: WIDTH must be a nonzero multiple of 4. Any other value stops elaboration with an error.
- R8: With both operands all ones and `cin_i`=1, a carry passes through every slice: the sum is all ones and `cout_o`=1. With `a_i` all ones, `b_i`=0 and `cin_i`=1, the sum is 0 and `cout_o`=1.
- R9: With all inputs at zero, the sum and `cout_o` are zero. With zero operands and `cin_i`=1, the sum is 1 and `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into the least significant column |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant slice |

## Verification
The assertions are immediate checks inside combinational processes. They assume that every input bit holds a known 0 or 1. They also assume the inputs have settled, so each check compares slice outputs that come from the same operand values. The stimulus keeps to this. All operands and the carry-in start at zero, and each new vector changes every input in one assignment. Outputs are read one time unit later, after the whole carry network has re-evaluated.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W = 4;

  typedef struct packed {
    logic gen;
    logic prop;
  } gp_t;
endpackage

// File: rtl/cla_fa.sv
module cla_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o,
  output logic g_o,
  output logic p_o
);
  logic x;

  assign g_o = a_i & b_i;
  assign p_o = a_i | b_i;
  assign x   = a_i ^ b_i;
  assign s_o = x ^ c_i;
  assign c_o = g_o | (p_o & c_i);

  always_comb begin
    AST_FA_ARITH: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {1'b0, c_i}))
      else $error("full adder mismatch"); // R2
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned GW = GRP_W
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output gp_t           gp_o,
  output logic          rc_o
);
  logic [GW:0]   chain;
  logic [GW-1:0] g_col;
  logic [GW-1:0] p_col;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < GW; i++) begin : g_col_fa
    cla_fa u_fa (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (chain[i]),
      .s_o (sum_o[i]),
      .c_o (chain[i+1]),
      .g_o (g_col[i]),
      .p_o (p_col[i])
    );
  end

  assign rc_o = chain[GW];

  // slice generate: fold from column 0 upward
  always_comb begin
    logic acc;
    acc = g_col[0];
    for (int i = 1; i < GW; i++) acc = g_col[i] | (p_col[i] & acc);
    gp_o.gen  = acc;
    gp_o.prop = &p_col;
  end

  always_comb begin
    AST_GRP_GEN_OUT: assert (!gp_o.gen || rc_o)
      else $error("slice generates but ripple carry low"); // R3
    AST_GRP_KILL: assert (gp_o.gen || gp_o.prop || !rc_o)
      else $error("slice neither generates nor propagates yet carries"); // R3
    AST_GRP_PASS: assert (gp_o.gen || !gp_o.prop || (rc_o == cin_i))
      else $error("propagating slice did not pass carry-in"); // R3
  end
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
  import cla_pkg::*;
#(
  parameter int unsigned N_GRP = 8
) (
  input  gp_t [N_GRP-1:0] gp_i,
  input  logic            cin_i,
  output logic [N_GRP:0]  c_o
);
  assign c_o[0] = cin_i;

  for (genvar k = 0; k < N_GRP; k++) begin : g_step
    assign c_o[k+1] = gp_i[k].gen | (gp_i[k].prop & c_o[k]);
  end

  always_comb begin
    AST_CARRY_SEED: assert (c_o[0] == cin_i)
      else $error("slice 0 carry not driven by carry-in"); // R4
    for (int k = 0; k < N_GRP; k++) begin
      AST_CARRY_GEN: assert (!gp_i[k].gen || c_o[k+1])
        else $error("generating slice yields no carry"); // R4
      AST_CARRY_BLOCK: assert (gp_i[k].gen || gp_i[k].prop || !c_o[k+1])
        else $error("blocking slice yields carry"); // R4
    end
  end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  localparam int unsigned N_GRP = WIDTH / GRP_W;

  if ((WIDTH == 0) || (WIDTH % GRP_W != 0)) begin : g_bad_width
    $error("WIDTH must be a nonzero multiple of 4"); // R7
  end

  gp_t  [N_GRP-1:0] gp;
  logic [N_GRP:0]   carry;
  logic [N_GRP-1:0] ripple_c;

  cla_carry_unit #(.N_GRP(N_GRP)) u_carry (
    .gp_i  (gp),
    .cin_i (cin_i),
    .c_o   (carry)
  );

  for (genvar k = 0; k < N_GRP; k++) begin : g_slice
    cla_group #(.GW(GRP_W)) u_grp (
      .a_i   (a_i[k*GRP_W +: GRP_W]),
      .b_i   (b_i[k*GRP_W +: GRP_W]),
      .cin_i (carry[k]),
      .sum_o (sum_o[k*GRP_W +: GRP_W]),
      .gp_o  (gp[k]),
      .rc_o  (ripple_c[k])
    );
  end

  assign cout_o = carry[N_GRP];

  always_comb begin
    AST_TOTAL_SUM: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("adder result mismatch"); // R1
    AST_COUT_TOP: assert (cout_o == ripple_c[N_GRP-1])
      else $error("carry-out disagrees with top slice ripple"); // R6
    for (int k = 0; k < N_GRP; k++) begin
      AST_RIPPLE_MATCH: assert (ripple_c[k] == carry[k+1])
        else $error("ripple and lookahead carries differ"); // R5
    end
  end
endmodule

// File: tb/cla_adder_tb_top.sv
module cla_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N_VEC = 10;

  // {a, b, cin}
  localparam logic [2*W:0] VEC [N_VEC] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    {32'h0000_000F, 32'h0000_0001, 1'b0},
    {32'h0000_00F0, 32'h0000_0010, 1'b0},
    {32'h0FFF_FFFF, 32'h0000_0001, 1'b0},
    {32'h7FFF_FFFF, 32'h0000_0001, 1'b0},
    {32'h1234_5678, 32'h9ABC_DEF0, 1'b0},
    {32'hAAAA_AAAA, 32'h5555_5555, 1'b1},
    {32'hFFFF_0000, 32'h0000_FFFF, 1'b0},
    {32'h8000_0000, 32'h8000_0000, 1'b1}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a = '0, b = '0, sum;
  logic cin = 1'b0, cout;
  logic [7:0] a8 = '0, b8 = '0, sum8;
  logic cin8 = 1'b0, cout8;

  int n_chk = 0;
  int n_err = 0;

  cla_adder #(.WIDTH(W)) dut_i (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  cla_adder #(.WIDTH(8)) dut8_i (
    .a_i(a8), .b_i(b8), .cin_i(cin8), .sum_o(sum8), .cout_o(cout8)
  );

  task automatic chk32(input logic [W-1:0] va, input logic [W-1:0] vb,
                       input logic vc, input string req);
    logic [W:0] exp;
    a = va; b = vb; cin = vc;
    #1;
    exp = {1'b0, va} + {1'b0, vb} + {{W{1'b0}}, vc};
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_err++;
      $display("FAIL %s a=%h b=%h cin=%0b actual=%h expected=%h", req, va, vb, vc, {cout, sum}, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    #1;
    // R9 idle state with zero inputs
    n_chk++;
    if ({cout, sum} !== '0) begin
      n_err++;
      $display("FAIL R9 idle actual=%h expected=0", {cout, sum});
    end
    chk32('0, '0, 1'b1, "R9 zero plus carry-in");

    for (int i = 0; i < N_VEC; i++)
      chk32(VEC[i][2*W:W+1], VEC[i][W:1], VEC[i][0], "R1 table");

    chk32('1, '1, 1'b1, "R8 all ones with carry-in");
    chk32('1, '0, 1'b1, "R8 carry through every slice");
    chk32(32'h1, 32'h1, 1'b0, "R2 column generate");
    chk32(32'h1, 32'h0, 1'b1, "R2 column propagate");
    chk32(32'h0000_000E, 32'h0000_0001, 1'b1, "R3 slice propagate");
    chk32(32'h0000_0008, 32'h0000_0008, 1'b0, "R3 slice generate top column");
    chk32(32'h0FFF_FFF0, 32'h0000_0010, 1'b0, "R4 lookahead across slices");
    chk32(32'h0000_0FFF, 32'h0000_0000, 1'b1, "R5 ripple inside and across slices");
    chk32(32'hF000_0000, 32'h1000_0000, 1'b0, "R6 carry-out from top slice");
    chk32(32'hEFFF_FFFF, 32'h1000_0000, 1'b1, "R6 top slice propagates");

    for (int i = 0; i < 2000; i++)
      chk32($urandom, $urandom, 1'($urandom), "R1 random");

    // R7 accepted width of 8, exhaustive
    for (int c = 0; c < 2; c++) begin
      for (int x = 0; x < 256; x++) begin
        for (int y = 0; y < 256; y++) begin
          logic [8:0] e8;
          a8 = 8'(x); b8 = 8'(y); cin8 = 1'(c);
          #1;
          e8 = 9'(x) + 9'(y) + 9'(c);
          n_chk++;
          if ({cout8, sum8} !== e8) begin
            n_err++;
            $display("FAIL R7 width8 a=%h b=%h cin=%0d actual=%h expected=%h", a8, b8, c, {cout8, sum8}, e8);
          end
        end
      end
    end
    summary();
  end
endmodule